// File: doc/BRIEF.md
# Interlocked Strobe Bus Transfer Pair

This block contains a bus initiator and a memory responder that move one word at a time. No shared bus cycle length governs the transfer. The initiator places an address, a memory-request line and a read/write select on the bus. It then raises its request strobe and waits. The responder notices that strobe and performs the access after a configurable number of working cycles. It then raises its acknowledge strobe, with read data already valid. The initiator lowers its strobe only after it sees the acknowledge. The responder lowers the acknowledge only after it sees the request strobe go low. A fast responder therefore finishes the transfer sooner than a slow one.

Both ends are clocked state machines. Each end passes the other end's strobe through a two-flop synchronizer before acting on it. The initiator gives up after a programmable number of clocks without an acknowledge, reports an error and returns to idle. The responder holds a small word memory written so that block RAM can be inferred. The bus lines are brought out as outputs so that the handshake can be observed.

Top module: `hs_bus_pair`

## Requirements
- R1: While reset is high and in the cycle after it is released, `busy`, `done`, `err`, `bus_req`, `bus_ack` and `bus_mreq` are all 0.
- R2: The initiator drives `bus_mreq`=1 and the address and select (`bus_rd`=1 means read, 0 means write) at least one clock before `bus_req` rises. It keeps them unchanged until it has seen `bus_ack` low again.
- R3: The responder starts work only after its synchronized copy of `bus_req` is high. It raises `bus_ack` after `slv_delay` working cycles, with `bus_rdata` already valid. It keeps `bus_ack` and `bus_rdata` unchanged until it sees `bus_req` low.
- R4: `bus_req` falls only after the synchronized `bus_ack` has been seen high, unless a timeout occurs. `bus_ack` falls only after the synchronized `bus_req` has been seen low.
- R5: A write stores `wdata` at `addr`. A read ends with a one-cycle `done` pulse, and `rd_data` then holds the word last written to `addr`.
- R6: The time from `start` to `done` grows by exactly one clock for each extra cycle of `slv_delay`.
- R7: If the acknowledge is not seen within `to_limit` clocks of `bus_req` rising, the initiator pulses `err` for one cycle, gives no `done`, drops `bus_req` and `bus_mreq`, and returns to idle.
- R8: A `start` that arrives while `busy` is 1 is ignored. The ongoing transfer still completes, and the memory is not changed by the ignored request.
- R9: A write that the responder has begun still lands in memory when the initiator timed out on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ends |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a transfer (accepted when idle) |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| to_limit | input | TW | Clocks to wait for acknowledge |
| slv_delay | input | LW | Responder working cycles |
| busy | output | 1 | Initiator not idle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle timeout pulse |
| rd_data | output | DW | Word returned by the last read |
| bus_req | output | 1 | Initiator strobe on the bus |
| bus_ack | output | 1 | Responder strobe on the bus |
| bus_mreq | output | 1 | Memory-request line |
| bus_rd | output | 1 | Read select line |
| bus_addr | output | AW | Address lines |
| bus_rdata | output | DW | Read data lines from responder |

## Verification
The bench varies the responder latency between transfers and compares the start-to-done times for two latencies. A design that tied completion to a fixed cycle count would show no difference, or the wrong one. A start pulse that targets the same address during a read must leave that word intact. A design that accepted it would corrupt memory or produce a second completion. A slow responder paired with a short limit must give an error and no completion, and the abandoned write must still reach memory. A bus monitor flags any strobe that rises before the request lines, any address change while the request is held, and any acknowledge that drops while the request strobe is still high.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    M_IDLE    = 2'd0,
    M_SETUP   = 2'd1,
    M_STROBE  = 2'd2,
    M_RELEASE = 2'd3
  } m_state_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WORK = 2'd1,
    S_ACK  = 2'd2
  } s_state_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hs_master.sv
module hs_master
  import hs_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int TW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [TW-1:0] to_limit,
  input  logic          ack_in,
  input  logic [DW-1:0] rdata_in,
  output logic          req,
  output logic          mreq,
  output logic          rd_sel,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rd_data
);
  m_state_t state;
  logic [TW-1:0] wait_cnt;
  logic ack_s;

  hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst(rst), .d(ack_in), .q(ack_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= M_IDLE;
      wait_cnt  <= '0;
      req       <= 1'b0;
      mreq      <= 1'b0;
      rd_sel    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      rd_data   <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        M_IDLE: begin
          if (start && !ack_s) begin
            bus_addr  <= addr;
            bus_wdata <= wdata;
            rd_sel    <= !wr;
            mreq      <= 1'b1;
            state     <= M_SETUP;
          end
        end
        M_SETUP: begin
          req      <= 1'b1;
          wait_cnt <= '0;
          state    <= M_STROBE;
        end
        M_STROBE: begin
          if (ack_s) begin
            if (rd_sel) rd_data <= rdata_in;
            req   <= 1'b0;
            state <= M_RELEASE;
          end else if (wait_cnt >= to_limit) begin
            req   <= 1'b0;
            mreq  <= 1'b0;
            err   <= 1'b1;
            state <= M_IDLE;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        M_RELEASE: begin
          if (!ack_s) begin
            mreq  <= 1'b0;
            done  <= 1'b1;
            state <= M_IDLE;
          end
        end
        default: state <= M_IDLE;
      endcase
    end
  end

  assign busy = (state != M_IDLE);

  // R2
  setup_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> $past(mreq));
  // R2
  lines_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mreq && $past(mreq)) |-> ($stable(bus_addr) && $stable(rd_sel)));
  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(req) && !err) |-> $past(ack_s));
  // R7
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (!done && !req));
endmodule

// File: rtl/hs_slave.sv
module hs_slave
  import hs_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int LW = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_in,
  input  logic          rd_sel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [LW-1:0] delay,
  output logic          ack,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  s_state_t state;
  logic [LW-1:0] work_cnt;
  logic req_s;
  logic do_access;
  logic [DW-1:0] mem [DEPTH];

  hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst(rst), .d(req_in), .q(req_s)
  );

  assign do_access = (state == S_WORK) && (work_cnt >= delay);

  always_ff @(posedge clk) begin
    if (do_access && !rd_sel) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (do_access && rd_sel) begin
      rdata <= mem[addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      work_cnt <= '0;
      ack      <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          work_cnt <= '0;
          if (req_s) state <= S_WORK;
        end
        S_WORK: begin
          if (do_access) begin
            ack   <= 1'b1;
            state <= S_ACK;
          end else begin
            work_cnt <= work_cnt + 1'b1;
          end
        end
        S_ACK: begin
          if (!req_s) begin
            ack   <= 1'b0;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3
  start_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(state == S_WORK)) |-> $past(req_s));
  // R3
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && req_s) |=> ack);
  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && $past(ack)) |-> $stable(rdata));
  // R4
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack) |-> !$past(req_s));
endmodule

// File: rtl/hs_bus_pair.sv
module hs_bus_pair #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int TW = 8,
  parameter int LW = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [TW-1:0] to_limit,
  input  logic [LW-1:0] slv_delay,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rd_data,
  output logic          bus_req,
  output logic          bus_ack,
  output logic          bus_mreq,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_rdata
);
  logic [DW-1:0] bus_wdata;

  hs_master #(.AW(AW), .DW(DW), .TW(TW), .SYNC_STAGES(SYNC_STAGES)) u_master (
    .clk(clk), .rst(rst), .start(start), .wr(wr), .addr(addr), .wdata(wdata),
    .to_limit(to_limit), .ack_in(bus_ack), .rdata_in(bus_rdata),
    .req(bus_req), .mreq(bus_mreq), .rd_sel(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .done(done), .err(err), .rd_data(rd_data)
  );

  hs_slave #(.AW(AW), .DW(DW), .LW(LW), .SYNC_STAGES(SYNC_STAGES)) u_slave (
    .clk(clk), .rst(rst), .req_in(bus_req), .rd_sel(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .delay(slv_delay), .ack(bus_ack), .rdata(bus_rdata)
  );
endmodule

// File: tb/hs_bus_pair_test.sv
module hs_bus_pair_test;
  localparam int AW = 4, DW = 16, TW = 8, LW = 6;

  logic clk = 0, rst = 1;
  logic start = 0, wr = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [TW-1:0] to_limit = 8'd200;
  logic [LW-1:0] slv_delay = '0;
  logic busy, done, err, bus_req, bus_ack, bus_mreq, bus_rd;
  logic [DW-1:0] rd_data, bus_rdata;
  logic [AW-1:0] bus_addr;

  int checks = 0, errors = 0, cyc = 0;
  int viol_order = 0, viol_hold = 0, viol_ack = 0;
  logic [DW-1:0] model [1<<AW];
  logic p_req, p_mreq, p_ack; logic [AW-1:0] p_addr;

  always #10 clk = ~clk;

  hs_bus_pair #(.AW(AW), .DW(DW), .TW(TW), .LW(LW)) uut (
    .clk(clk), .rst(rst), .start(start), .wr(wr), .addr(addr), .wdata(wdata),
    .to_limit(to_limit), .slv_delay(slv_delay), .busy(busy), .done(done),
    .err(err), .rd_data(rd_data), .bus_req(bus_req), .bus_ack(bus_ack),
    .bus_mreq(bus_mreq), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
  );

  function automatic logic [DW-1:0] expect_read(input logic [AW-1:0] a);
    return model[a];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus monitor (R2, R4)
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (bus_req && !p_req && !p_mreq) viol_order++;
      if (bus_mreq && p_mreq && bus_addr != p_addr) viol_hold++;
      if (!bus_ack && p_ack && bus_req) viol_ack++;
    end
    p_req = bus_req; p_mreq = bus_mreq; p_ack = bus_ack; p_addr = bus_addr;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic xfer(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int dly, output int cycles, output bit got_done,
                      output bit got_err, output logic [DW-1:0] rv);
    @(negedge clk);
    wr = w; addr = a; wdata = d; slv_delay = LW'(dly); start = 1;
    @(negedge clk);
    start = 0;
    cycles = 1; got_done = 0; got_err = 0; rv = '0;
    while (!got_done && !got_err && cycles < 2000) begin
      if (done) begin got_done = 1; rv = rd_data; end
      else if (err) got_err = 1;
      else begin @(negedge clk); cycles++; end
    end
    if (got_done && w) model[a] = d;
  endtask

  task automatic idle_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int c, c1, c2; bit dn, er; logic [DW-1:0] rv, keep;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !done && !err && !bus_req && !bus_ack && !bus_mreq, "R1", {busy, bus_req, bus_ack, bus_mreq}, 0);
    rst = 0;
    @(negedge clk);
    check(!busy && !bus_req && !bus_ack && !bus_mreq && !done, "R1", {busy, bus_req, bus_ack, bus_mreq}, 0);

    // fill memory (R5)
    for (int a = 0; a < (1<<AW); a++) begin
      xfer(1, AW'(a), DW'($urandom), $urandom_range(0, 5), c, dn, er, rv);
      check(dn && !er, "R5", dn, 1);
    end
    // read back (R5, R3)
    for (int a = 0; a < (1<<AW); a++) begin
      xfer(0, AW'(a), '0, $urandom_range(0, 7), c, dn, er, rv);
      check(dn && rv == expect_read(AW'(a)), "R5", rv, expect_read(AW'(a)));
    end
    // random mix (R5)
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a; bit w;
      a = AW'($urandom); w = $urandom_range(0, 1) == 1;
      xfer(w, a, DW'($urandom), $urandom_range(0, 10), c, dn, er, rv);
      if (w) check(dn, "R5", dn, 1);
      else   check(dn && rv == expect_read(a), "R5", rv, expect_read(a));
    end
    // directed: zero and maximum latency reads
    xfer(0, AW'(0), '0, 0, c, dn, er, rv);
    check(dn && rv == expect_read(AW'(0)), "R3", rv, expect_read(AW'(0)));
    xfer(0, AW'((1<<AW)-1), '0, 63, c, dn, er, rv);
    check(dn && rv == expect_read(AW'((1<<AW)-1)), "R3", rv, expect_read(AW'((1<<AW)-1)));

    // R6 latency adaptation
    xfer(0, AW'(2), '0, 1, c1, dn, er, rv);
    xfer(0, AW'(2), '0, 6, c2, dn, er, rv);
    check(c2 - c1 == 5, "R6", c2 - c1, 5);

    // R7 timeout, R9 abandoned write lands
    to_limit = 8'd8;
    xfer(1, AW'(3), 16'hBEEF, 30, c, dn, er, rv);
    check(er && !dn, "R7", {dn, er}, 2'b01);
    @(negedge clk);
    check(!bus_req && !bus_mreq && !busy, "R7", {bus_req, bus_mreq, busy}, 0);
    model[3] = 16'hBEEF;
    idle_wait(80);
    to_limit = 8'd200;
    xfer(0, AW'(3), '0, 2, c, dn, er, rv);
    check(dn && rv == 16'hBEEF, "R9", rv, 16'hBEEF);

    // R8 start while busy ignored
    keep = expect_read(AW'(5));
    @(negedge clk);
    wr = 0; addr = AW'(5); slv_delay = LW'(10); start = 1;
    @(negedge clk);
    start = 0;
    idle_wait(3);
    wr = 1; addr = AW'(5); wdata = ~keep; start = 1;
    @(negedge clk);
    start = 0;
    c = 0;
    while (!done && c < 500) begin @(negedge clk); c++; end
    check(done && rd_data == keep, "R8", rd_data, keep);
    @(negedge clk);
    idle_wait(10);
    check(!busy && !done, "R8", {busy, done}, 0);
    xfer(0, AW'(5), '0, 0, c, dn, er, rv);
    check(dn && rv == keep, "R8", rv, keep);

    // handshake ordering summaries
    check(viol_order == 0 && viol_hold == 0, "R2", viol_order + viol_hold, 0);
    check(viol_ack == 0, "R4", viol_ack, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule